// File: doc/BRIEF.md
# Multi-port serial interrupt and register hub

This block sits in front of a bank of up to sixteen 16550-style serial cores and owns a 16 KiB byte-addressed register window. The lower 4 KiB hold a small bank of 32-bit global registers. It holds a fixed identification word, the number of ports built, a live interrupt status vector, and two enable masks. Each mask has a write-one-to-set address and a write-one-to-clear address, and the clear address reads back the inverted mask. Everything above the global bank is cut into 512-byte windows, one per port. Accesses that land in the lower half of a window go out on a shared request/response bus to the serial core that owns the window. Accesses to the upper half, which holds DMA registers, and accesses to windows past the last port are acknowledged and discarded.

Each core raises a level interrupt request. The hub registers these levels into the status vector and drives one level-sensitive interrupt line. The line is high while any status bit has its enable bit set. The second mask records which ports may wake the system and never touches the interrupt line.

The host side takes one access at a time. A request is accepted while `host_ready` is high, and each access ends with a single-cycle `host_rsp_valid` pulse. Global and discarded accesses answer one cycle after acceptance. Forwarded accesses answer once the port has taken the request and, for reads, has returned its data.

Top module: `uart_irq_hub`

## Requirements
- R1: A read of offset 0x000 returns 0x00070002 and a read of offset 0x004 returns the configured port count NPORTS (1 to 16). Writes to either offset leave both values unchanged.
- R2: A read of offset 0x008 returns the status vector, in which bit i holds the interrupt request of port i as sampled at the previous clock edge. Bits at or above NPORTS read 0, and writes to 0x008 have no effect.
- R3: A write to offset 0x00C ORs the write data into the 32-bit interrupt enable mask, and a read of 0x00C returns that mask.
- R4: A write to offset 0x010 clears each enable mask bit that is 1 in the write data, and a read of 0x010 returns the bitwise inverse of the mask.
- R5: Offsets 0x014 (set) and 0x018 (clear, inverse read) give the same behaviour for a separate wake mask. Writes there change neither the interrupt enable mask nor `irq_o`.
- R6: `irq_o` is high exactly when (status AND interrupt enable) is nonzero. It reflects a change of `port_irq` one clock later, and it reflects an enable write in the cycle after that write is accepted.
- R7: A read of any offset below 0x1000 that is not listed in R1 to R5 returns 0.
- R8: Reset clears the status vector and both masks and drives `irq_o` low, `host_ready` high and `host_rsp_valid` low.
- R9: An access that is not forwarded gets its `host_rsp_valid` pulse exactly one cycle after acceptance. The pulse lasts one cycle.
- R10: An access at offset A ≥ 0x1000 targets port (A−0x1000)/0x200 at sub-offset (A−0x1000) mod 0x200. When the port exists and the sub-offset is below 0x100, the access is forwarded with `port_sel` set to the port, `port_addr` to the sub-offset, and the host's write flag and data.
- R11: An access whose port index is NPORTS or more is never forwarded. It reads 0, and a write to it is discarded.
- R12: An access to sub-offset 0x100 to 0x1FF of an existing port's window is never forwarded. It reads 0, and a write to it is discarded.
- R13: `port_req_valid` stays high with stable `port_sel`, `port_addr`, `port_wdata` and `port_req_write` until `port_req_ready`. For a forwarded read, the host response waits for `port_rsp_valid` and carries `port_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_valid | input | 1 | Host request present |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 14 | Byte offset in the window |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | Hub can accept a request |
| host_rsp_valid | output | 1 | One-cycle response pulse |
| host_rdata | output | 32 | Read data, valid with the response |
| port_irq | input | NPORTS | Interrupt request level of each port |
| irq_o | output | 1 | Combined level interrupt |
| port_req_valid | output | 1 | Forwarded request present |
| port_req_write | output | 1 | Forwarded request is a write |
| port_sel | output | 4 | Target port index |
| port_addr | output | 8 | Sub-offset within the port window |
| port_wdata | output | 32 | Forwarded write data |
| port_req_ready | input | 1 | Selected port takes the request |
| port_rsp_valid | input | 1 | Selected port returns read data |
| port_rdata | input | 32 | Port read data |

## Verification
The bench builds the hub with NPORTS = 5. With that value, windows 5 to 23 lie inside the address range but past the last port, so the discard path for missing ports can be reached. The upper bits of the status vector stay at zero while the masks keep all 32 bits. A port responder with an adjustable delay covers forwarding without wait and with several wait cycles on both the request and the data return.

// File: rtl/uart_hub_pkg.sv
package uart_hub_pkg;
  localparam int HUB_AW     = 14;
  localparam int HUB_DW     = 32;
  localparam int MAX_PORTS  = 16;
  localparam int PSEL_W     = 4;
  localparam int GLB_SPAN   = 'h1000;
  localparam int WIN_LOG    = 9;          // 0x200-byte port windows
  localparam int DMA_LOG    = 8;          // upper half of a window is DMA
  localparam int IDX_W      = HUB_AW - WIN_LOG;
  localparam logic [HUB_DW-1:0] HUB_ID_WORD = 32'h0007_0002;

  localparam logic [11:0] OFF_IDENT   = 12'h000;
  localparam logic [11:0] OFF_COUNT   = 12'h004;
  localparam logic [11:0] OFF_STATUS  = 12'h008;
  localparam logic [11:0] OFF_IEN_SET = 12'h00C;
  localparam logic [11:0] OFF_IEN_CLR = 12'h010;
  localparam logic [11:0] OFF_WEN_SET = 12'h014;
  localparam logic [11:0] OFF_WEN_CLR = 12'h018;

  typedef enum logic [1:0] {ACC_GLOBAL, ACC_FORWARD, ACC_DROP} acc_kind_e;
  typedef enum logic [1:0] {XS_IDLE, XS_FWD_REQ, XS_FWD_RSP, XS_DONE} xact_state_e;

  // offset relative to the first port window
  function automatic logic [HUB_AW-1:0] win_rel(input logic [HUB_AW-1:0] a);
    return a - HUB_AW'(GLB_SPAN);
  endfunction

  // window index = relative offset divided by the window size
  function automatic logic [IDX_W-1:0] win_index(input logic [HUB_AW-1:0] a);
    logic [HUB_AW-1:0] rel;
    rel = win_rel(a);
    return rel[HUB_AW-1:WIN_LOG];
  endfunction

  // sub-offset = relative offset modulo the window size
  function automatic logic [WIN_LOG-1:0] win_sub(input logic [HUB_AW-1:0] a);
    logic [HUB_AW-1:0] rel;
    rel = win_rel(a);
    return rel[WIN_LOG-1:0];
  endfunction
endpackage

// File: rtl/hub_addr_decode.sv
module hub_addr_decode
  import uart_hub_pkg::*;
#(
  parameter int NPORTS = 16
) (
  input  logic [HUB_AW-1:0]  addr,
  output acc_kind_e          kind,
  output logic [PSEL_W-1:0]  sel,
  output logic [DMA_LOG-1:0] sub_addr
);
  logic [IDX_W-1:0]   idx;
  logic [WIN_LOG-1:0] sub;
  logic               is_global;
  logic               port_exists;
  logic               in_dma;

  assign idx         = win_index(addr);
  assign sub         = win_sub(addr);
  assign is_global   = (int'(addr) < GLB_SPAN);
  assign port_exists = (int'(idx) < NPORTS);
  assign in_dma      = sub[DMA_LOG];
  assign sel         = idx[PSEL_W-1:0];
  assign sub_addr    = sub[DMA_LOG-1:0];

  always_comb begin
    if (is_global)                      kind = ACC_GLOBAL;
    else if (port_exists && !in_dma)    kind = ACC_FORWARD;
    else                                kind = ACC_DROP;
  end
endmodule

// File: rtl/hub_global_regs.sv
module hub_global_regs
  import uart_hub_pkg::*;
#(
  parameter int NPORTS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] port_irq,
  input  logic              glb_wr,
  input  logic [11:0]       off,
  input  logic [HUB_DW-1:0] wdata,
  output logic [HUB_DW-1:0] rdata,
  output logic              irq_o
);
  logic [NPORTS-1:0] status_q;
  logic [HUB_DW-1:0] ien_q;
  logic [HUB_DW-1:0] wen_q;
  logic ien_set_wr, ien_clr_wr, wen_set_wr, wen_clr_wr, wen_wr;

  assign ien_set_wr = glb_wr && (off == OFF_IEN_SET);
  assign ien_clr_wr = glb_wr && (off == OFF_IEN_CLR);
  assign wen_set_wr = glb_wr && (off == OFF_WEN_SET);
  assign wen_clr_wr = glb_wr && (off == OFF_WEN_CLR);
  assign wen_wr     = wen_set_wr || wen_clr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ien_q    <= '0;
      wen_q    <= '0;
    end else begin
      status_q <= port_irq;
      if (ien_set_wr) ien_q <= ien_q | wdata;
      if (ien_clr_wr) ien_q <= ien_q & ~wdata;
      if (wen_set_wr) wen_q <= wen_q | wdata;
      if (wen_clr_wr) wen_q <= wen_q & ~wdata;
    end
  end

  assign irq_o = |(status_q & ien_q[NPORTS-1:0]);

  always_comb begin
    case (off)
      OFF_IDENT:   rdata = HUB_ID_WORD;
      OFF_COUNT:   rdata = HUB_DW'(NPORTS);
      OFF_STATUS:  rdata = HUB_DW'(status_q);
      OFF_IEN_SET: rdata = ien_q;
      OFF_IEN_CLR: rdata = ~ien_q;
      OFF_WEN_SET: rdata = wen_q;
      OFF_WEN_CLR: rdata = ~wen_q;
      default:     rdata = '0;
    endcase
  end

  // R3
  ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ien_set_wr |=> ((ien_q & $past(wdata)) == $past(wdata)));
  // R4
  ien_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr_wr |=> ((ien_q & $past(wdata)) == '0));
  // R5
  wake_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wen_wr |=> $stable(ien_q));
  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq_o);
endmodule

// File: rtl/hub_xact_ctrl.sv
module hub_xact_ctrl
  import uart_hub_pkg::*;
#(
  parameter int NPORTS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic               host_write,
  input  logic [HUB_DW-1:0]  host_wdata,
  output logic               host_ready,
  output logic               host_rsp_valid,
  output logic [HUB_DW-1:0]  host_rdata,
  input  acc_kind_e          kind,
  input  logic [PSEL_W-1:0]  dec_sel,
  input  logic [DMA_LOG-1:0] dec_sub,
  input  logic [HUB_DW-1:0]  glb_rdata,
  output logic               glb_wr,
  output logic               port_req_valid,
  output logic               port_req_write,
  output logic [PSEL_W-1:0]  port_sel,
  output logic [DMA_LOG-1:0] port_addr,
  output logic [HUB_DW-1:0]  port_wdata,
  input  logic               port_req_ready,
  input  logic               port_rsp_valid,
  input  logic [HUB_DW-1:0]  port_rdata
);
  xact_state_e       state_q;
  logic [HUB_DW-1:0] rdata_q;
  logic              accept, fwd_start, fwd_handoff, fwd_return;

  assign accept      = host_valid && (state_q == XS_IDLE);
  assign fwd_start   = accept && (kind == ACC_FORWARD);
  assign fwd_handoff = (state_q == XS_FWD_REQ) && port_req_ready;
  assign fwd_return  = (state_q == XS_FWD_RSP) && port_rsp_valid;
  assign glb_wr      = accept && host_write && (kind == ACC_GLOBAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= XS_IDLE;
      rdata_q        <= '0;
      port_req_write <= 1'b0;
      port_sel       <= '0;
      port_addr      <= '0;
      port_wdata     <= '0;
    end else begin
      case (state_q)
        XS_IDLE: if (accept) begin
          if (fwd_start) begin
            port_req_write <= host_write;
            port_sel       <= dec_sel;
            port_addr      <= dec_sub;
            port_wdata     <= host_wdata;
            state_q        <= XS_FWD_REQ;
          end else begin
            rdata_q <= (kind == ACC_GLOBAL && !host_write) ? glb_rdata : '0;
            state_q <= XS_DONE;
          end
        end
        XS_FWD_REQ: if (fwd_handoff) begin
          rdata_q <= '0;
          state_q <= port_req_write ? XS_DONE : XS_FWD_RSP;
        end
        XS_FWD_RSP: if (fwd_return) begin
          rdata_q <= port_rdata;
          state_q <= XS_DONE;
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign host_ready     = (state_q == XS_IDLE);
  assign host_rsp_valid = (state_q == XS_DONE);
  assign host_rdata     = rdata_q;
  assign port_req_valid = (state_q == XS_FWD_REQ);

  // R13
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_req_valid && !port_req_ready) |=>
      (port_req_valid && $stable(port_sel) && $stable(port_addr) && $stable(port_wdata)));
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |=> (!host_rsp_valid && host_ready));
  // R11
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_req_valid |-> (int'(port_sel) < NPORTS));
  // R13
  rsp_after_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_rsp_valid) && $past(state_q) == XS_FWD_RSP) |-> (host_rdata == $past(port_rdata)));
endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub
  import uart_hub_pkg::*;
#(
  parameter int NPORTS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic               host_write,
  input  logic [HUB_AW-1:0]  host_addr,
  input  logic [HUB_DW-1:0]  host_wdata,
  output logic               host_ready,
  output logic               host_rsp_valid,
  output logic [HUB_DW-1:0]  host_rdata,
  input  logic [NPORTS-1:0]  port_irq,
  output logic               irq_o,
  output logic               port_req_valid,
  output logic               port_req_write,
  output logic [PSEL_W-1:0]  port_sel,
  output logic [DMA_LOG-1:0] port_addr,
  output logic [HUB_DW-1:0]  port_wdata,
  input  logic               port_req_ready,
  input  logic               port_rsp_valid,
  input  logic [HUB_DW-1:0]  port_rdata
);
  acc_kind_e          kind;
  logic [PSEL_W-1:0]  dec_sel;
  logic [DMA_LOG-1:0] dec_sub;
  logic [HUB_DW-1:0]  glb_rdata;
  logic               glb_wr;

  hub_addr_decode #(.NPORTS(NPORTS)) u_dec (
    .addr(host_addr), .kind(kind), .sel(dec_sel), .sub_addr(dec_sub)
  );

  hub_global_regs #(.NPORTS(NPORTS)) u_regs (
    .clk(clk), .rst_n(rst_n), .port_irq(port_irq), .glb_wr(glb_wr),
    .off(host_addr[11:0]), .wdata(host_wdata), .rdata(glb_rdata), .irq_o(irq_o)
  );

  hub_xact_ctrl #(.NPORTS(NPORTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_write(host_write), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rsp_valid(host_rsp_valid), .host_rdata(host_rdata),
    .kind(kind), .dec_sel(dec_sel), .dec_sub(dec_sub),
    .glb_rdata(glb_rdata), .glb_wr(glb_wr),
    .port_req_valid(port_req_valid), .port_req_write(port_req_write),
    .port_sel(port_sel), .port_addr(port_addr), .port_wdata(port_wdata),
    .port_req_ready(port_req_ready), .port_rsp_valid(port_rsp_valid),
    .port_rdata(port_rdata)
  );
endmodule

// File: tb/uart_irq_hub_bench.sv
module uart_irq_hub_bench;
  localparam int NP = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        host_valid, host_write;
  logic [13:0] host_addr;
  logic [31:0] host_wdata;
  logic        host_ready, host_rsp_valid;
  logic [31:0] host_rdata;
  logic [NP-1:0] port_irq;
  logic        irq_o;
  logic        port_req_valid, port_req_write;
  logic [3:0]  port_sel;
  logic [7:0]  port_addr;
  logic [31:0] port_wdata;
  logic        port_req_ready, port_rsp_valid;
  logic [31:0] port_rdata;

  uart_irq_hub #(.NPORTS(NP)) u_uart_irq_hub (.*);

  int total = 0, bad = 0;
  logic [31:0] m_ien = 0, m_wen = 0;
  int fwd_cnt = 0, port_delay = 0;
  logic [3:0]  f_sel;
  logic [7:0]  f_addr;
  logic [31:0] f_wd;
  logic        f_wr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] port_pattern(input logic [3:0] s, input logic [7:0] a);
    return {16'hB0A7, s, 4'h0, a};
  endfunction

  // reference model of the masks, irq compared every clock (R6)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ien = 0; m_wen = 0;
    end else if (host_valid && host_ready && host_write && host_addr < 14'h1000) begin
      case (host_addr)
        14'h00C: m_ien = m_ien | host_wdata;
        14'h010: m_ien = m_ien & ~host_wdata;
        14'h014: m_wen = m_wen | host_wdata;
        14'h018: m_wen = m_wen & ~host_wdata;
        default: ;
      endcase
    end
    #2;
    chk("R6 irq_o per-clock", {31'b0, irq_o}, {31'b0, |(port_irq & m_ien[NP-1:0])});
  end

  // port responder
  initial begin
    port_req_ready = 0; port_rsp_valid = 0; port_rdata = 0;
    forever begin
      @(negedge clk);
      if (port_req_valid) begin
        logic [7:0] first_addr;
        logic [3:0] first_sel;
        first_addr = port_addr; first_sel = port_sel;
        repeat (port_delay) @(negedge clk);
        chk("R13 held request", {20'b0, port_req_valid, port_sel, port_addr}, {20'b0, 1'b1, first_sel, first_addr});
        port_req_ready = 1;
        fwd_cnt++;
        f_sel = port_sel; f_addr = port_addr; f_wd = port_wdata; f_wr = port_req_write;
        @(negedge clk);
        port_req_ready = 0;
        if (!f_wr) begin
          repeat (port_delay) @(negedge clk);
          port_rsp_valid = 1;
          port_rdata = port_pattern(f_sel, f_addr);
          @(negedge clk);
          port_rsp_valid = 0;
          port_rdata = 0;
        end
      end
    end
  end

  task automatic xfer(input logic wr, input logic [13:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int lat);
    @(negedge clk);
    host_valid = 1; host_write = wr; host_addr = a; host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 0; host_write = 0;
    lat = 1;
    while (!host_rsp_valid) begin @(negedge clk); lat++; end
    rd = host_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [13:0] a, input logic [31:0] exp);
    logic [31:0] v; int l;
    xfer(1'b0, a, 32'h0, v, l);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    logic [31:0] v; int l;
    xfer(1'b1, a, d, v, l);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] v; int l; int snap;
    rst_n = 0; host_valid = 0; host_write = 0; host_addr = 0; host_wdata = 0; port_irq = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 irq_o in reset", {31'b0, irq_o}, 0);
    chk("R8 host_ready in reset", {31'b0, host_ready}, 1);
    chk("R8 rsp_valid in reset", {31'b0, host_rsp_valid}, 0);
    rst_n = 1;
    rd_chk("R8 ien after reset", 14'h00C, 0);
    rd_chk("R8 wake after reset", 14'h014, 0);
    rd_chk("R8 status after reset", 14'h008, 0);

    // R1 identification and count, R9 latency
    xfer(1'b0, 14'h000, 0, v, l);
    chk("R1 ident", v, 32'h0007_0002);
    chk("R9 global latency", l, 1);
    wr(14'h000, 32'h1234_5678);
    rd_chk("R1 ident after write", 14'h000, 32'h0007_0002);
    rd_chk("R1 count", 14'h004, NP);
    wr(14'h004, 32'hFF);
    rd_chk("R1 count after write", 14'h004, NP);

    // R2 status
    @(negedge clk); port_irq = 5'b10110;
    @(negedge clk); @(negedge clk);
    rd_chk("R2 status", 14'h008, 32'h16);
    wr(14'h008, 32'hFFFF_FFFF);
    rd_chk("R2 status after write", 14'h008, 32'h16);

    // R3 set
    wr(14'h00C, 32'h5);
    wr(14'h00C, 32'h0010_0002);
    rd_chk("R3 ien or", 14'h00C, 32'h0010_0007);
    @(negedge clk);
    chk("R6 irq high", {31'b0, irq_o}, 1);

    // R4 clear
    rd_chk("R4 inverse read", 14'h010, ~32'h0010_0007);
    wr(14'h010, 32'h6);
    rd_chk("R4 ien cleared", 14'h00C, 32'h0010_0001);
    @(negedge clk);
    chk("R6 irq low", {31'b0, irq_o}, 0);
    port_irq = 5'b10111;
    @(negedge clk); @(negedge clk);
    chk("R6 irq follows port", {31'b0, irq_o}, 1);

    // R5 wake mask
    wr(14'h014, 32'h0F0F);
    wr(14'h018, 32'h000F);
    rd_chk("R5 wake set/clear", 14'h014, 32'h0F00);
    rd_chk("R5 wake inverse", 14'h018, ~32'h0F00);
    rd_chk("R5 ien untouched", 14'h00C, 32'h0010_0001);

    // R7 undefined global offsets
    rd_chk("R7 off 0x1C", 14'h01C, 0);
    rd_chk("R7 off 0x800", 14'h800, 0);
    rd_chk("R7 off 0xFFC", 14'hFFC, 0);
    rd_chk("R7 off 0x002", 14'h002, 0);

    // R10 forwarding
    port_delay = 0;
    rd_chk("R10 fwd read data", 14'h1404, port_pattern(4'd2, 8'h04));
    chk("R10 fwd read sel/addr", {20'b0, f_wr, f_sel, f_addr}, {20'b0, 1'b0, 4'd2, 8'h04});
    wr(14'h1820, 32'hDEAD_BEEF);
    chk("R10 fwd write fields", {19'b0, f_wr, f_sel, f_addr}, {19'b0, 1'b1, 4'd4, 8'h20});
    chk("R10 fwd write data", f_wd, 32'hDEAD_BEEF);

    // R13 delayed port
    port_delay = 3;
    xfer(1'b0, 14'h12FF, 0, v, l);
    chk("R13 delayed read data", v, port_pattern(4'd1, 8'hFF));
    chk("R13 response waited", {31'b0, l > 6}, 1);
    port_delay = 0;

    // R11 missing ports
    snap = fwd_cnt;
    rd_chk("R11 port 5 read", 14'h1A00, 0);
    wr(14'h1A00, 32'h1);
    rd_chk("R11 window 23 read", 14'h3FFC, 0);
    chk("R11 nothing forwarded", fwd_cnt, snap);

    // R12 DMA sub-range
    xfer(1'b0, 14'h1100, 0, v, l);
    chk("R12 DMA read", v, 0);
    chk("R9 dropped latency", l, 1);
    wr(14'h13FC, 32'h55);
    chk("R12 nothing forwarded", fwd_cnt, snap);
    rd_chk("R12 ien untouched", 14'h00C, 32'h0010_0001);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule